// File: doc/BRIEF.md
# UART FIFO Ready-Signal Controller

This block holds the transmit and receive byte queues of a UART-style peripheral and derives the two ready strobes that a host or a block-transfer engine watches: `txrdy` and `rxrdy`. The host writes bytes destined for the line into the transmit queue. The shifter drains that queue. The deserializer fills the receive queue, and the host empties it. Serial shifting, baud generation and clocking sit outside this block.

An 8-bit control write selects one of three modes. With queues off, each direction behaves as a single holding byte. With queues on and burst mode off, the strobes report data presence and complete emptiness. With queues on and burst mode on, the receive strobe waits for a programmed fill level or a timeout pulse, and the transmit strobe reports free space. The two strobes are also placed in a status byte and sit beside two line-status flags.

All four data paths use valid/ready. A transfer happens only in a cycle where both valid and ready are high. Each ready depends on the current queue fill alone and never on the valid it answers. A valid offered while ready is low is dropped, so the sender must hold it until ready returns. When a queue is empty its output data reads 0x00.

Top module: `uart_rdy_ctrl`

## Requirements
- R1: Control word fields: bit 0 enables the queues, bit 3 turns on burst mode, which acts only while bit 0 is 1, and bits 7:6 select the receive fill level (00=1, 01=4, 10=8, 11=14 bytes). A write that changes bit 0 empties both queues.
- R2: With queues off, each direction holds one byte. `rxrdy` is 1 exactly when the receive byte is present. `txrdy` is 1 exactly when the transmit byte is absent.
- R3: With queues on and burst mode off, `rxrdy` is 1 when the receive queue holds at least one byte. `txrdy` is 1 only when the transmit queue is empty.
- R4: In burst mode `rxrdy` rises once the receive fill reaches the selected level, or in the cycle after a `rx_timeout` pulse that arrives while the queue is non-empty. It then stays 1 until the receive queue is empty.
- R5: In burst mode `txrdy` is 1 while the transmit queue has at least one free slot, and 0 when it holds 16 bytes.
- R6: `int_stat` bit 5 equals `rxrdy` and bit 4 equals `txrdy`. All other bits are 0.
- R7: With queues on, each queue holds 16 bytes and delivers them in arrival order.
- R8: A control write with bit 1 set empties the receive queue, and one with bit 2 set empties the transmit queue, at the edge ending that write. An input transfer offered in the same cycle is discarded. These bits are not kept, so later writes without them clear nothing.
- R9: A transmit byte offered while the queue is full is ignored. Reading the receive side while it is empty returns 0x00 and changes nothing.
- R10: `thr_empty` is 1 when the transmit queue is empty, and `rx_avail` is 1 when the receive queue is non-empty. Both reflect a transfer from the cycle after it.
- R11: `tx_in_ready`/`rx_in_ready` are 1 while the fill is below capacity (16 with queues on, 1 with queues off). `tx_out_valid`/`rx_out_valid` are 1 while the queue is non-empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_wr | input | 1 | Control word write strobe |
| ctrl_data | input | 8 | Control word |
| rx_timeout | input | 1 | Single-cycle receive timeout pulse |
| tx_in_valid | input | 1 | Host offers a transmit byte |
| tx_in_data | input | 8 | Transmit byte from host |
| tx_in_ready | output | 1 | Transmit queue accepts a byte |
| tx_out_valid | output | 1 | Transmit byte available to shifter |
| tx_out_data | output | 8 | Oldest transmit byte, 0x00 when empty |
| tx_out_ready | input | 1 | Shifter takes the byte |
| rx_in_valid | input | 1 | Deserializer offers a byte |
| rx_in_data | input | 8 | Received byte |
| rx_in_ready | output | 1 | Receive queue accepts a byte |
| rx_out_valid | output | 1 | Received byte available to host |
| rx_out_data | output | 8 | Oldest received byte, 0x00 when empty |
| rx_out_ready | input | 1 | Host reads the byte |
| txrdy | output | 1 | Transmit ready strobe |
| rxrdy | output | 1 | Receive ready strobe |
| int_stat | output | 8 | Status byte carrying the strobes |
| thr_empty | output | 1 | Transmit queue empty flag |
| rx_avail | output | 1 | Receive data present flag |

## Verification
Two pairs of events can collide in one cycle. A clear bit in a control write can coincide with an offered input byte on the same queue, and the clear must win so the queue reads empty next cycle. A timeout pulse can coincide with the read that drains the last byte, and `rxrdy` must then drop rather than stay latched. The bench forces both pairs in directed steps. It then lets random traffic with sparse control writes and timeout pulses produce further collisions. Each cycle it compares every output with a queue-level model.

// File: rtl/uart_rdy_pkg.sv
package uart_rdy_pkg;

  typedef struct packed {
    logic       fifo_en;
    logic       burst;
    logic [1:0] lvl_sel;
  } mode_t;

  // receive fill level selected by the two-bit field
  function automatic int unsigned lvl_bytes(input logic [1:0] sel);
    case (sel)
      2'b00:   return 1;
      2'b01:   return 4;
      2'b10:   return 8;
      default: return 14;
    endcase
  endfunction

endpackage

// File: rtl/uart_ctrl_reg.sv
module uart_ctrl_reg
  import uart_rdy_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ctrl_wr,
  input  logic [7:0]    ctrl_data,
  output mode_t         mode,
  output logic          burst_eff,
  output logic [CW-1:0] lvl,
  output logic [CW-1:0] cap,
  output logic          rx_clr,
  output logic          tx_clr
);

  logic en_flip;
  logic unused_bits;

  assign unused_bits = ^ctrl_data[5:4];
  assign en_flip     = ctrl_wr && (ctrl_data[0] != mode.fifo_en);
  // clear bits act in the write cycle only and are never stored
  assign rx_clr      = ctrl_wr && (ctrl_data[1] || en_flip);
  assign tx_clr      = ctrl_wr && (ctrl_data[2] || en_flip);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode <= '0;
    end else if (ctrl_wr) begin
      mode.fifo_en <= ctrl_data[0];
      mode.burst   <= ctrl_data[3];
      mode.lvl_sel <= ctrl_data[7:6];
    end
  end

  assign burst_eff = mode.fifo_en && mode.burst;
  assign lvl       = CW'(lvl_bytes(mode.lvl_sel));
  assign cap       = mode.fifo_en ? CW'(DEPTH) : CW'(1);

endmodule

// File: rtl/uart_byte_fifo.sv
module uart_byte_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic [CW-1:0] cap,
  input  logic          in_valid,
  input  logic [W-1:0]  in_data,
  output logic          in_ready,
  output logic          out_valid,
  output logic [W-1:0]  out_data,
  input  logic          out_ready,
  output logic [CW-1:0] count
);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          push, pop;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign in_ready  = count < cap;
  assign out_valid = count != '0;
  assign out_data  = out_valid ? mem[rd_ptr] : '0;
  assign push      = in_valid && in_ready && !clr;
  assign pop       = out_valid && out_ready && !clr;

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= in_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (clr) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= bump(wr_ptr);
      if (pop)  rd_ptr <= bump(rd_ptr);
      count <= count + CW'(push) - CW'(pop);
    end
  end

  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));

  assert_clear_empties_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (count == '0));

  assert_full_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_ready && !clr && !(out_valid && out_ready)) |=> $stable(count));

endmodule

// File: rtl/uart_rdy_logic.sv
module uart_rdy_logic #(
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          burst_eff,
  input  logic [CW-1:0] lvl,
  input  logic [CW-1:0] rx_cnt,
  input  logic [CW-1:0] tx_cnt,
  input  logic          rx_timeout,
  input  logic          rx_clr,
  output logic          txrdy,
  output logic          rxrdy
);

  logic rx_nz, hit, arm_q, arm_d;

  assign rx_nz = rx_cnt != '0;
  assign hit   = rx_cnt >= lvl;
  // latch the burst condition until the receive side drains
  assign arm_d = burst_eff && rx_nz && !rx_clr && (arm_q || rx_timeout || hit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) arm_q <= 1'b0;
    else        arm_q <= arm_d;
  end

  always_comb begin
    if (burst_eff) begin
      txrdy = tx_cnt < CW'(DEPTH);
      rxrdy = rx_nz && (arm_q || hit);
    end else begin
      txrdy = tx_cnt == '0;
      rxrdy = rx_nz;
    end
  end

  assert_rx_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_eff && rxrdy) |=> (rxrdy || rx_cnt == '0 || !burst_eff));

  assert_timeout_arms_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_eff && rx_timeout && rx_nz && !rx_clr && !$past(rx_clr) && $stable(burst_eff))
      |=> (rxrdy || rx_cnt == '0 || !burst_eff));

endmodule

// File: rtl/uart_rdy_ctrl.sv
module uart_rdy_ctrl
  import uart_rdy_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_wr,
  input  logic [7:0]        ctrl_data,
  input  logic              rx_timeout,
  input  logic              tx_in_valid,
  input  logic [DATA_W-1:0] tx_in_data,
  output logic              tx_in_ready,
  output logic              tx_out_valid,
  output logic [DATA_W-1:0] tx_out_data,
  input  logic              tx_out_ready,
  input  logic              rx_in_valid,
  input  logic [DATA_W-1:0] rx_in_data,
  output logic              rx_in_ready,
  output logic              rx_out_valid,
  output logic [DATA_W-1:0] rx_out_data,
  input  logic              rx_out_ready,
  output logic              txrdy,
  output logic              rxrdy,
  output logic [7:0]        int_stat,
  output logic              thr_empty,
  output logic              rx_avail
);

  localparam int CW = $clog2(DEPTH + 1);

  mode_t         mode;
  logic          burst_eff, rx_clr, tx_clr;
  logic [CW-1:0] lvl, cap, tx_cnt, rx_cnt;

  uart_ctrl_reg #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .ctrl_data(ctrl_data),
    .mode(mode), .burst_eff(burst_eff), .lvl(lvl), .cap(cap),
    .rx_clr(rx_clr), .tx_clr(tx_clr)
  );

  uart_byte_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n), .clr(tx_clr), .cap(cap),
    .in_valid(tx_in_valid), .in_data(tx_in_data), .in_ready(tx_in_ready),
    .out_valid(tx_out_valid), .out_data(tx_out_data), .out_ready(tx_out_ready),
    .count(tx_cnt)
  );

  uart_byte_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n), .clr(rx_clr), .cap(cap),
    .in_valid(rx_in_valid), .in_data(rx_in_data), .in_ready(rx_in_ready),
    .out_valid(rx_out_valid), .out_data(rx_out_data), .out_ready(rx_out_ready),
    .count(rx_cnt)
  );

  uart_rdy_logic #(.DEPTH(DEPTH)) u_rdy (
    .clk(clk), .rst_n(rst_n), .burst_eff(burst_eff), .lvl(lvl),
    .rx_cnt(rx_cnt), .tx_cnt(tx_cnt), .rx_timeout(rx_timeout),
    .rx_clr(rx_clr), .txrdy(txrdy), .rxrdy(rxrdy)
  );

  assign int_stat  = {2'b00, rxrdy, txrdy, 4'b0000};
  assign thr_empty = tx_cnt == '0;
  assign rx_avail  = rx_cnt != '0;

  assert_rxrdy_has_data_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rxrdy |-> rx_out_valid);

  assert_tx_flag_after_push_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_in_valid && tx_in_ready && !tx_clr) |=> !thr_empty);

  assert_burst_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_eff && !tx_in_ready) |-> !txrdy);

endmodule

// File: tb/uart_rdy_ctrl_tb.sv
module uart_rdy_ctrl_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ctrl_wr = 1'b0;
  logic [7:0] ctrl_data = '0;
  logic       rx_timeout = 1'b0;
  logic       tx_in_valid = 1'b0, tx_out_ready = 1'b0;
  logic       rx_in_valid = 1'b0, rx_out_ready = 1'b0;
  logic [7:0] tx_in_data = '0, rx_in_data = '0;
  logic       tx_in_ready, tx_out_valid, rx_in_ready, rx_out_valid;
  logic [7:0] tx_out_data, rx_out_data, int_stat;
  logic       txrdy, rxrdy, thr_empty, rx_avail;

  int checks = 0;
  int fails  = 0;

  // queue-level model
  bit         m_en, m_burst, m_arm;
  bit [1:0]   m_sel;
  logic [7:0] txq[$];
  logic [7:0] rxq[$];

  always #2 clk = ~clk;

  uart_rdy_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .ctrl_data(ctrl_data),
    .rx_timeout(rx_timeout),
    .tx_in_valid(tx_in_valid), .tx_in_data(tx_in_data), .tx_in_ready(tx_in_ready),
    .tx_out_valid(tx_out_valid), .tx_out_data(tx_out_data), .tx_out_ready(tx_out_ready),
    .rx_in_valid(rx_in_valid), .rx_in_data(rx_in_data), .rx_in_ready(rx_in_ready),
    .rx_out_valid(rx_out_valid), .rx_out_data(rx_out_data), .rx_out_ready(rx_out_ready),
    .txrdy(txrdy), .rxrdy(rxrdy), .int_stat(int_stat),
    .thr_empty(thr_empty), .rx_avail(rx_avail)
  );

  function automatic int lvl_of(input bit [1:0] s);
    case (s)
      2'd0: return 1;
      2'd1: return 4;
      2'd2: return 8;
      default: return 14;
    endcase
  endfunction

  function automatic int cap_of();
    return m_en ? 16 : 1;
  endfunction

  function automatic bit exp_txrdy();
    if (m_en && m_burst) return txq.size() < 16;
    return txq.size() == 0;
  endfunction

  function automatic bit exp_rxrdy();
    if (m_en && m_burst) return rxq.size() != 0 && (m_arm || rxq.size() >= lvl_of(m_sel));
    return rxq.size() != 0;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_all();
    string mt;
    mt = m_en ? (m_burst ? "R5" : "R3") : "R2";
    chk({mt, " txrdy"}, 32'(txrdy), 32'(exp_txrdy()));
    mt = m_en ? (m_burst ? "R4" : "R3") : "R2";
    chk({mt, " rxrdy"}, 32'(rxrdy), 32'(exp_rxrdy()));
    chk("R6 int_stat", 32'(int_stat), 32'({2'b00, exp_rxrdy(), exp_txrdy(), 4'b0}));
    chk("R10 thr_empty", 32'(thr_empty), 32'(txq.size() == 0));
    chk("R10 rx_avail", 32'(rx_avail), 32'(rxq.size() != 0));
    chk("R11 tx_in_ready", 32'(tx_in_ready), 32'(txq.size() < cap_of()));
    chk("R11 rx_in_ready", 32'(rx_in_ready), 32'(rxq.size() < cap_of()));
    chk("R11 tx_out_valid", 32'(tx_out_valid), 32'(txq.size() != 0));
    chk("R11 rx_out_valid", 32'(rx_out_valid), 32'(rxq.size() != 0));
    chk("R7 tx_out_data", 32'(tx_out_data), 32'(txq.size() != 0 ? txq[0] : 8'h00));
    chk("R7 rx_out_data", 32'(rx_out_data), 32'(rxq.size() != 0 ? rxq[0] : 8'h00));
  endtask

  // one cycle with the inputs currently driven; model advances in step
  task automatic step();
    int  tn, rn;
    bit  tpush, tpop, rpush, rpop, flip, ctx, crx, n_arm;
    tn    = txq.size();
    rn    = rxq.size();
    tpush = tx_in_valid && tn < cap_of();
    tpop  = tx_out_ready && tn > 0;
    rpush = rx_in_valid && rn < cap_of();
    rpop  = rx_out_ready && rn > 0;
    flip  = ctrl_wr && (ctrl_data[0] != m_en);
    ctx   = ctrl_wr && (ctrl_data[2] || flip);
    crx   = ctrl_wr && (ctrl_data[1] || flip);
    n_arm = (rn != 0) && m_en && m_burst && !crx &&
            (m_arm || rx_timeout || rn >= lvl_of(m_sel));
    @(posedge clk);
    if (ctx) txq.delete();
    else begin
      if (tpop)  void'(txq.pop_front());
      if (tpush) txq.push_back(tx_in_data);
    end
    if (crx) rxq.delete();
    else begin
      if (rpop)  void'(rxq.pop_front());
      if (rpush) rxq.push_back(rx_in_data);
    end
    if (ctrl_wr) begin
      m_en    = ctrl_data[0];
      m_burst = ctrl_data[3];
      m_sel   = ctrl_data[7:6];
    end
    m_arm = n_arm;
    @(negedge clk);
    check_all();
    ctrl_wr = 0; rx_timeout = 0;
    tx_in_valid = 0; tx_out_ready = 0; rx_in_valid = 0; rx_out_ready = 0;
  endtask

  task automatic wr_ctrl(input logic [7:0] d);
    ctrl_wr = 1; ctrl_data = d; step();
  endtask

  task automatic put_rx(input logic [7:0] d);
    rx_in_valid = 1; rx_in_data = d; step();
  endtask

  task automatic put_tx(input logic [7:0] d);
    tx_in_valid = 1; tx_in_data = d; step();
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state: queues off, both empty
    chk("R2 reset txrdy", 32'(txrdy), 32'd1);
    chk("R2 reset rxrdy", 32'(rxrdy), 32'd0);
    check_all();

    // single holding byte per direction
    put_tx(8'hA5);
    chk("R2 tx holding full", 32'(tx_in_ready), 32'd0);
    put_tx(8'h11);
    put_rx(8'h3C);
    chk("R2 rx byte present", 32'(rxrdy), 32'd1);
    tx_out_ready = 1; step();

    // queues on, burst on, level 4 (0100_1001)
    wr_ctrl(8'h49);
    chk("R1 toggle empties rx", 32'(rx_avail), 32'd0);
    for (int i = 0; i < 3; i++) put_rx(8'(8'h20 + i));
    chk("R1 below level 4", 32'(rxrdy), 32'd0);
    put_rx(8'h23);
    chk("R1 R4 level 4 reached", 32'(rxrdy), 32'd1);
    rx_out_ready = 1; step();
    chk("R4 held after read", 32'(rxrdy), 32'd1);
    for (int i = 0; i < 3; i++) begin rx_out_ready = 1; step(); end
    chk("R4 drops when empty", 32'(rxrdy), 32'd0);
    rx_out_ready = 1; step();
    chk("R9 empty read data", 32'(rx_out_data), 32'h00);

    // timeout arms with one byte, collides with drain later
    put_rx(8'h77);
    chk("R4 one byte no level", 32'(rxrdy), 32'd0);
    rx_timeout = 1; step();
    chk("R4 timeout arms", 32'(rxrdy), 32'd1);
    rx_timeout = 1; rx_out_ready = 1; step();
    chk("R4 timeout with drain", 32'(rxrdy), 32'd0);

    // fill transmit queue past capacity
    for (int i = 0; i < 17; i++) put_tx(8'(8'h40 + i));
    chk("R5 full txrdy", 32'(txrdy), 32'd0);
    for (int i = 0; i < 16; i++) begin
      chk("R9 R7 drain order", 32'(tx_out_data), 32'(8'h40 + i));
      tx_out_ready = 1; step();
    end
    chk("R9 overflow dropped", 32'(tx_out_valid), 32'd0);

    // clear colliding with push
    put_tx(8'h01); put_tx(8'h02);
    ctrl_wr = 1; ctrl_data = 8'h4D; tx_in_valid = 1; tx_in_data = 8'h03; step();
    chk("R8 clear beats push", 32'(thr_empty), 32'd1);
    put_tx(8'h04);
    wr_ctrl(8'h49);
    chk("R8 clear not kept", 32'(thr_empty), 32'd0);
    put_rx(8'h05);
    wr_ctrl(8'h4B);
    chk("R8 rx clear", 32'(rx_avail), 32'd0);

    // queues on, burst off
    wr_ctrl(8'h01);
    put_tx(8'h10);
    chk("R3 txrdy needs empty", 32'(txrdy), 32'd0);

    // random traffic
    for (int n = 0; n < 4000; n++) begin
      tx_in_valid  = ($urandom % 2) == 0;
      tx_in_data   = 8'($urandom);
      tx_out_ready = ($urandom % 5) < 2;
      rx_in_valid  = ($urandom % 2) == 0;
      rx_in_data   = 8'($urandom);
      rx_out_ready = ($urandom % 5) < 2;
      rx_timeout   = ($urandom % 32) == 0;
      if (($urandom % 64) == 0) begin
        ctrl_wr   = 1;
        ctrl_data = 8'($urandom) & 8'hCF;
        ctrl_data[0] = ($urandom % 8) != 0;
        if (($urandom % 4) != 0) ctrl_data[2:1] = 2'b00;
      end
      step();
    end

    finish_run();
  end

endmodule